// File: doc/BRIEF.md
# Low-Speed USB Packet Receiver

This block turns the two wires of a low-speed USB device port into a stream of received packet bytes. Both wires are brought into the local clock domain through two-flop synchronisers. A free-running fractional bit timer produces one sampling point per bit cell. The nominal spacing is `CLK_NUM/CLK_DEN` clocks, which defaults to 40/3, about 13.33. While the receiver searches for the start of a packet, it restarts the timer on every J-to-K transition. This places each sample near the middle of a bit cell.

Once the sync field has ended with two K bit times in a row, the receiver decodes the line with NRZI and drops the stuff bit that follows every run of six ones. It assembles bytes least significant bit first and presents each one as a single-cycle `byteValid` pulse with `byteData`. A single-ended zero at a sampling point ends the packet with `pktDone`. A per-packet byte budget guards the consumer: one byte too many raises `overflowPulse` and discards the rest of the packet. Bus activity that never turns into a sync raises `markerPulse`, which covers keep-alive markers and broken sync attempts. While the companion transmitter drives the bus (`txActive`), the receiver ignores the bus.

Top module: `usbLsRx`

## Requirements
- R1: Line states are decoded from the synchronised pair {dpIn,dmIn} as J = 2'b01 (also idle), K = 2'b10 and SE0 = 2'b00. Each input passes through two flops before any comparison.
- R2: While the receiver searches for sync, every J-to-K transition restarts the bit timer so that the first sample falls about half a bit later. Consecutive samples are then floor(CLK_NUM/CLK_DEN) or ceil(CLK_NUM/CLK_DEN) clocks apart (13 or 14 by default), and the spacing averages exactly CLK_NUM/CLK_DEN.
- R3: Sync is accepted only when the sample after a K sample is also K. If that second sample is J, the search resumes. The data bits start with the next sample, and the reference line state is K.
- R4: Equal consecutive line states decode to 1 and a change decodes to 0. Bits fill the byte from bit 0 upward. After eight data bits, `byteValid` pulses for one cycle with the byte on `byteData`.
- R5: The last sync bit counts as the first one of a run. After six consecutive 1s the next bit is a stuff bit: it only updates the reference line state, it never enters a byte, and it resets the run.
- R6: SE0 at a sampling point during the data phase pulses `pktDone` for one cycle. Incomplete bits of the current byte are dropped.
- R7: A budget of MAX_BYTES is loaded when sync is accepted. When a byte completes after the budget is used up, the receiver pulses `overflowPulse` instead of `byteValid`, gives no `pktDone`, and ignores the bus until SE0 and then J.
- R8: A search that receives no J-to-K transition within HUNT_CLKS clocks pulses `markerPulse` and delivers no byte. A search starts either from SE0 on an idle bus or from a failed second-K check.
- R9: While `txActive` is high, no output pulses. After `txActive` falls, reception resumes only once the bus shows J.
- R10: After reset all outputs are 0, and at most one of `byteValid`, `pktDone`, `overflowPulse` and `markerPulse` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock, about 13.33 cycles per low-speed bit |
| rstN | input | 1 | Asynchronous active-low reset |
| dpIn | input | 1 | D+ line, asynchronous |
| dmIn | input | 1 | D- line, asynchronous |
| txActive | input | 1 | High while the companion transmitter drives the bus |
| byteValid | output | 1 | One-cycle pulse, a received byte is on byteData |
| byteData | output | 8 | Received byte, bit 0 received first |
| pktDone | output | 1 | One-cycle pulse at the end-of-packet SE0 |
| overflowPulse | output | 1 | One-cycle pulse when the byte budget is exceeded |
| markerPulse | output | 1 | One-cycle pulse when bus activity produced no sync |

## Verification
The assertions check the following on every cycle:
- Sample spacing stays at 13 or 14 clocks once the timer runs freely.
- The output pulses are mutually exclusive.
- Nothing pulses while the transmitter owns the bus.
- No byte is delivered beyond the budget, and overflow fires exactly at the budget.
- `pktDone` follows an SE0 line state.

The bench's scenarios show the rest:
- Every byte value is recovered through NRZI and stuffing.
- A single K does not count as sync.
- Keep-alive SE0 and broken sync produce a marker.
- Truncated and empty packets still end cleanly.
- Reception works again after an overflowed or transmitter-masked packet.

// File: rtl/usbLsRxPkg.sv
package usbLsRxPkg;

  // Line state encoded as {dp, dm}
  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } lineState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic restartTimer;  // realign the bit timer to a J-to-K edge
    logic startPacket;   // sync accepted: load budget, clear assembly state
    logic takeBit;       // process the current sample as a data/stuff bit
  } rxStrobes_t;

  typedef enum logic [2:0] {
    ST_WAITJ,
    ST_IDLE,
    ST_HUNT,
    ST_SYNC1,
    ST_SYNC2,
    ST_RECV,
    ST_DRAIN
  } rxState_t;

endpackage

// File: rtl/usbLsRxData.sv
module usbLsRxData
  import usbLsRxPkg::*;
#(
  parameter int CLK_NUM   = 40,
  parameter int CLK_DEN   = 3,
  parameter int MAX_BYTES = 11
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dpIn,
  input  logic       dmIn,
  input  rxStrobes_t strobes,
  output lineState_t lineCur,
  output logic       edgeJK,
  output logic       tick,
  output logic       lastBitNext,
  output logic       budgetEmpty,
  output logic       byteValid,
  output logic [7:0] byteData,
  output logic       overflowPulse
);

  localparam int ACC_W     = $clog2(CLK_NUM + CLK_DEN + 1);
  localparam int SAMPLE_AT = (CLK_NUM / CLK_DEN) / 2;
  localparam logic [ACC_W-1:0] ACC_INIT = ACC_W'(CLK_NUM - SAMPLE_AT * CLK_DEN);
  localparam logic [ACC_W-1:0] STEP     = ACC_W'(CLK_DEN);
  localparam logic [ACC_W-1:0] WRAP     = ACC_W'(CLK_NUM);
  localparam int GAP_LO = CLK_NUM / CLK_DEN;
  localparam int GAP_HI = (CLK_NUM + CLK_DEN - 1) / CLK_DEN;
  localparam int GAP_W  = $clog2(GAP_HI + 2);
  localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};
  localparam int BUD_W  = $clog2(MAX_BYTES + 1);
  localparam logic [BUD_W-1:0] BUD_FULL = BUD_W'(MAX_BYTES);
  localparam logic [1:0] IDLE_PAIR = 2'b01;  // {dp, dm} at idle (J)
  localparam logic [2:0] RUN_LIMIT = 3'd6;

  // ---------------- input synchronisers (R1) ----------------
  logic [1:0] pinRaw;
  logic [1:0] pinSync;
  assign pinRaw = {dpIn, dmIn};

  for (genvar g = 0; g < 2; g++) begin : gSync
    logic stA, stB;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stA <= IDLE_PAIR[g];
        stB <= IDLE_PAIR[g];
      end else begin
        stA <= pinRaw[g];
        stB <= stA;
      end
    end
    assign pinSync[g] = stB;
  end

  lineState_t linePrev;
  assign lineCur = lineState_t'(pinSync);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) linePrev <= LS_J;
    else       linePrev <= lineCur;
  end

  assign edgeJK = (linePrev == LS_J) && (lineCur == LS_K);

  // ---------------- fractional bit timer (R2) ----------------
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] accNext;
  assign accNext = acc + STEP;
  assign tick    = (accNext >= WRAP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     acc <= '0;
    else if (strobes.restartTimer) acc <= ACC_INIT;
    else if (tick)                 acc <= accNext - WRAP;
    else                           acc <= accNext;
  end

  // ---------------- NRZI, unstuffing, assembly ----------------
  lineState_t       refState;
  logic [2:0]       onesRun;
  logic [2:0]       bitCount;
  logic [7:0]       shiftReg;
  logic [BUD_W-1:0] budget;
  logic             bitVal;
  logic             isStuff;
  logic [7:0]       shiftNext;

  assign bitVal      = (lineCur == refState);
  assign isStuff     = (onesRun == RUN_LIMIT);
  assign shiftNext   = {bitVal, shiftReg[7:1]};
  assign lastBitNext = (bitCount == 3'd7) && !isStuff;
  assign budgetEmpty = (budget == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refState <= LS_K;
      onesRun  <= 3'd0;
      bitCount <= 3'd0;
      shiftReg <= 8'h00;
      budget   <= '0;
    end else if (strobes.startPacket) begin
      refState <= LS_K;
      onesRun  <= 3'd1;         // final sync bit opens the run of ones
      bitCount <= 3'd0;
      shiftReg <= 8'h00;
      budget   <= BUD_FULL;
    end else if (strobes.takeBit) begin
      refState <= lineCur;
      if (isStuff) begin
        onesRun <= 3'd0;
      end else begin
        shiftReg <= shiftNext;
        bitCount <= bitCount + 3'd1;
        onesRun  <= bitVal ? onesRun + 3'd1 : 3'd0;
        if (bitCount == 3'd7 && !budgetEmpty) budget <= budget - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteValid     <= 1'b0;
      byteData      <= 8'h00;
      overflowPulse <= 1'b0;
    end else begin
      byteValid     <= strobes.takeBit && lastBitNext && !budgetEmpty;
      overflowPulse <= strobes.takeBit && lastBitNext && budgetEmpty;
      if (strobes.takeBit && lastBitNext && !budgetEmpty) byteData <= shiftNext;
    end
  end

  // ---------------- sample spacing checker ----------------
  logic [GAP_W-1:0] sinceTick;
  logic             gapValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceTick <= '0;
      gapValid  <= 1'b0;
    end else begin
      if (tick)                     sinceTick <= GAP_W'(1);
      else if (sinceTick != GAP_MAX) sinceTick <= sinceTick + 1'b1;
      if (strobes.restartTimer)     gapValid <= 1'b0;
      else if (tick)                gapValid <= 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && gapValid && !strobes.restartTimer) |->
      (sinceTick == GAP_W'(GAP_LO) || sinceTick == GAP_W'(GAP_HI)))
    else $error("tick spacing out of range");  // R2

endmodule

// File: rtl/usbLsRxCtrl.sv
module usbLsRxCtrl
  import usbLsRxPkg::*;
#(
  parameter int HUNT_CLKS = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       txActive,
  input  lineState_t lineCur,
  input  logic       edgeJK,
  input  logic       tick,
  input  logic       lastBitNext,
  input  logic       budgetEmpty,
  output rxStrobes_t strobes,
  output logic       pktDone,
  output logic       markerPulse
);

  localparam int WIN_W = $clog2(HUNT_CLKS + 1);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(HUNT_CLKS - 1);

  rxState_t         state, stateNext;
  logic [WIN_W-1:0] winCnt;
  logic             winClr;
  logic             doneSet;
  logic             markSet;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    winClr    = 1'b0;
    doneSet   = 1'b0;
    markSet   = 1'b0;
    if (txActive) begin
      stateNext = ST_WAITJ;                       // bus owned by transmitter
    end else begin
      unique case (state)
        ST_WAITJ: if (lineCur == LS_J) stateNext = ST_IDLE;
        ST_IDLE: begin
          if (edgeJK) begin
            strobes.restartTimer = 1'b1;
            stateNext = ST_SYNC1;
          end else if (lineCur == LS_SE0) begin
            winClr = 1'b1;
            stateNext = ST_HUNT;
          end
        end
        ST_HUNT: begin
          if (edgeJK) begin
            strobes.restartTimer = 1'b1;
            stateNext = ST_SYNC1;
          end else if (winCnt == WIN_LAST) begin
            markSet = 1'b1;
            stateNext = ST_WAITJ;
          end
        end
        ST_SYNC1: begin
          if (edgeJK) begin
            strobes.restartTimer = 1'b1;
          end else if (tick) begin
            if (lineCur == LS_K) stateNext = ST_SYNC2;
            else if (lineCur == LS_J) begin
              winClr = 1'b1;
              stateNext = ST_HUNT;
            end else stateNext = ST_WAITJ;
          end
        end
        ST_SYNC2: begin
          if (edgeJK) begin
            strobes.restartTimer = 1'b1;
            stateNext = ST_SYNC1;
          end else if (tick) begin
            if (lineCur == LS_K) begin
              strobes.startPacket = 1'b1;         // double K closes sync
              stateNext = ST_RECV;
            end else if (lineCur == LS_J) begin
              winClr = 1'b1;
              stateNext = ST_HUNT;
            end else stateNext = ST_WAITJ;
          end
        end
        ST_RECV: begin
          if (tick) begin
            if (lineCur == LS_SE0) begin
              doneSet = 1'b1;
              stateNext = ST_WAITJ;
            end else begin
              strobes.takeBit = 1'b1;
              if (lastBitNext && budgetEmpty) stateNext = ST_DRAIN;
            end
          end
        end
        ST_DRAIN: if (lineCur == LS_SE0) stateNext = ST_WAITJ;
        default: stateNext = ST_WAITJ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_WAITJ;
      winCnt      <= '0;
      pktDone     <= 1'b0;
      markerPulse <= 1'b0;
    end else begin
      state       <= stateNext;
      pktDone     <= doneSet;
      markerPulse <= markSet;
      if (winClr)                                   winCnt <= '0;
      else if (state == ST_HUNT && winCnt != WIN_LAST) winCnt <= winCnt + 1'b1;
    end
  end

  AST_DONE_AFTER_SE0: assert property (@(posedge clk) disable iff (!rstN)
    pktDone |-> $past(lineCur == LS_SE0))
    else $error("packet end without SE0");  // R6

endmodule

// File: rtl/usbLsRx.sv
module usbLsRx
  import usbLsRxPkg::*;
#(
  parameter int CLK_NUM   = 40,
  parameter int CLK_DEN   = 3,
  parameter int MAX_BYTES = 11,
  parameter int HUNT_CLKS = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dpIn,
  input  logic       dmIn,
  input  logic       txActive,
  output logic       byteValid,
  output logic [7:0] byteData,
  output logic       pktDone,
  output logic       overflowPulse,
  output logic       markerPulse
);

  localparam int BUD_W = $clog2(MAX_BYTES + 1);
  localparam logic [BUD_W-1:0] BUD_MAX = BUD_W'(MAX_BYTES);

  rxStrobes_t strobes;
  lineState_t lineCur;
  logic       edgeJK;
  logic       tick;
  logic       lastBitNext;
  logic       budgetEmpty;

  usbLsRxCtrl #(.HUNT_CLKS(HUNT_CLKS)) i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .txActive    (txActive),
    .lineCur     (lineCur),
    .edgeJK      (edgeJK),
    .tick        (tick),
    .lastBitNext (lastBitNext),
    .budgetEmpty (budgetEmpty),
    .strobes     (strobes),
    .pktDone     (pktDone),
    .markerPulse (markerPulse)
  );

  usbLsRxData #(
    .CLK_NUM   (CLK_NUM),
    .CLK_DEN   (CLK_DEN),
    .MAX_BYTES (MAX_BYTES)
  ) i_data (
    .clk           (clk),
    .rstN          (rstN),
    .dpIn          (dpIn),
    .dmIn          (dmIn),
    .strobes       (strobes),
    .lineCur       (lineCur),
    .edgeJK        (edgeJK),
    .tick          (tick),
    .lastBitNext   (lastBitNext),
    .budgetEmpty   (budgetEmpty),
    .byteValid     (byteValid),
    .byteData      (byteData),
    .overflowPulse (overflowPulse)
  );

  // Bytes delivered in the current packet, observed at the outputs
  logic [BUD_W-1:0] pktBytes;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                   pktBytes <= '0;
    else if (pktDone || overflowPulse || txActive) pktBytes <= '0;
    else if (byteValid)                          pktBytes <= pktBytes + 1'b1;
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({byteValid, pktDone, overflowPulse, markerPulse}))
    else $error("output pulses overlap");  // R10

  AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    txActive |=> !(byteValid || pktDone || overflowPulse || markerPulse))
    else $error("output while transmitting");  // R9

  AST_BYTE_BUDGET: assert property (@(posedge clk) disable iff (!rstN)
    byteValid |-> (pktBytes < BUD_MAX))
    else $error("byte beyond budget");  // R7

  AST_OVF_AT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    overflowPulse |-> (pktBytes == BUD_MAX))
    else $error("overflow before budget used");  // R7

endmodule

// File: tb/test_usbLsRx.sv
`timescale 1ns/1ps
module test_usbLsRx;
  localparam int NUM  = 40;
  localparam int DEN  = 3;
  localparam int MAXB = 4;
  localparam int HUNT = 40;
  localparam logic [1:0] LJ = 2'b01, LK = 2'b10, LSE0 = 2'b00;

  logic clk = 1'b0, rstN = 1'b0, dpIn = 1'b0, dmIn = 1'b1, txActive = 1'b0;
  logic byteValid, pktDone, overflowPulse, markerPulse;
  logic [7:0] byteData;

  always #2.5 clk = ~clk;

  usbLsRx #(.CLK_NUM(NUM), .CLK_DEN(DEN), .MAX_BYTES(MAXB), .HUNT_CLKS(HUNT)) i_usbLsRx (
    .clk(clk), .rstN(rstN), .dpIn(dpIn), .dmIn(dmIn), .txActive(txActive),
    .byteValid(byteValid), .byteData(byteData), .pktDone(pktDone),
    .overflowPulse(overflowPulse), .markerPulse(markerPulse));

  int total = 0, bad = 0;
  int gotN = 0, doneN = 0, ovfN = 0, markN = 0;
  logic [7:0] got [0:1023];
  logic [1:0] ls [0:1023];
  int lsN;
  logic [1:0] cur;
  int ones;
  bit finished = 0;
  int b0, d0, o0, m0;

  always @(negedge clk) begin
    if (rstN) begin
      if (byteValid) begin
        if (gotN < 1024) got[gotN] = byteData;
        gotN++;
      end
      if (pktDone) doneN++;
      if (overflowPulse) ovfN++;
      if (markerPulse) markN++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic pushLs(input logic [1:0] s);
    ls[lsN] = s;
    lsN++;
  endtask

  task automatic startSeq();
    lsN = 0;
    pushLs(LK); pushLs(LJ); pushLs(LK); pushLs(LJ);
    pushLs(LK); pushLs(LJ); pushLs(LK); pushLs(LK);
    cur = LK;
    ones = 1;
  endtask

  task automatic pushBit(input bit b);
    if (b) begin
      pushLs(cur);
      ones++;
    end else begin
      cur = ~cur;
      pushLs(cur);
      ones = 0;
    end
    if (ones == 6) begin
      cur = ~cur;
      pushLs(cur);
      ones = 0;
    end
  endtask

  task automatic pushByte(input logic [7:0] v, input int n);
    for (int i = 0; i < n; i++) pushBit(v[i]);
  endtask

  task automatic endSeq();
    pushLs(LSE0); pushLs(LSE0); pushLs(LJ);
  endtask

  task automatic play(input int gap);
    for (int k = 0; k < lsN; k++) begin
      {dpIn, dmIn} = ls[k];
      repeat (((k + 1) * NUM) / DEN - (k * NUM) / DEN) @(negedge clk);
    end
    {dpIn, dmIn} = LJ;
    repeat (gap) @(negedge clk);
  endtask

  task automatic mark();
    b0 = gotN; d0 = doneN; o0 = ovfN; m0 = markN;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk(byteValid == 0 && pktDone == 0 && overflowPulse == 0 && markerPulse == 0,
        "R10 reset outputs", int'({byteValid, pktDone, overflowPulse, markerPulse}), 0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);

    // Sweep every byte value, four per packet (exactly the budget)
    for (int p = 0; p < 64; p++) begin
      mark();
      startSeq();
      for (int i = 0; i < 4; i++) pushByte(8'(4 * p + i), 8);
      endSeq();
      play(40);
      chk(gotN - b0 == 4, "R4 byte count", gotN - b0, 4);
      for (int i = 0; i < 4; i++)
        chk(got[b0 + i] == 8'(4 * p + i), "R1/R4 byte value", int'(got[b0 + i]), 4 * p + i);
      chk(doneN - d0 == 1, "R6 packet end", doneN - d0, 1);
      chk(ovfN == o0 && markN == m0, "R10 no stray pulse", ovfN - o0 + markN - m0, 0);
    end

    // Long runs of ones: stuff bits everywhere, timer must not drift
    mark();
    startSeq();
    for (int i = 0; i < 4; i++) pushByte(8'hFF, 8);
    endSeq();
    play(40);
    chk(gotN - b0 == 4, "R5 stuffed count", gotN - b0, 4);
    for (int i = 0; i < 4; i++)
      chk(got[b0 + i] == 8'hFF, "R5/R2 stuffed value", int'(got[b0 + i]), 255);

    // Budget exceeded
    mark();
    startSeq();
    for (int i = 0; i < 5; i++) pushByte(8'(8'hA0 + i), 8);
    endSeq();
    play(40);
    chk(gotN - b0 == 4, "R7 bytes before overflow", gotN - b0, 4);
    chk(ovfN - o0 == 1, "R7 overflow pulse", ovfN - o0, 1);
    chk(doneN == d0, "R7 no done after overflow", doneN - d0, 0);

    // Recovery after overflow
    mark();
    startSeq();
    pushByte(8'h5A, 8);
    endSeq();
    play(40);
    chk(gotN - b0 == 1 && got[b0] == 8'h5A, "R7 recovery byte", int'(got[b0]), 90);
    chk(doneN - d0 == 1, "R7 recovery done", doneN - d0, 1);

    // Sync followed at once by SE0
    mark();
    startSeq();
    endSeq();
    play(40);
    chk(gotN == b0, "R6 empty packet bytes", gotN - b0, 0);
    chk(doneN - d0 == 1, "R6 empty packet done", doneN - d0, 1);

    // Byte plus four bits: partial byte dropped
    mark();
    startSeq();
    pushByte(8'hC3, 8);
    pushByte(8'h0F, 4);
    endSeq();
    play(40);
    chk(gotN - b0 == 1 && got[b0] == 8'hC3, "R6 partial byte dropped", gotN - b0, 1);
    chk(doneN - d0 == 1, "R6 partial packet done", doneN - d0, 1);

    // Single K then J: no double K, search window expires
    mark();
    lsN = 0;
    pushLs(LK); pushLs(LJ);
    play(80);
    chk(gotN == b0 && doneN == d0, "R3 single K not sync", gotN - b0 + doneN - d0, 0);
    chk(markN - m0 == 1, "R8 broken sync marker", markN - m0, 1);

    // Keep-alive style SE0 on idle bus
    mark();
    lsN = 0;
    pushLs(LSE0); pushLs(LSE0); pushLs(LJ);
    play(80);
    chk(markN - m0 == 1, "R8 keep-alive marker", markN - m0, 1);
    chk(doneN == d0 && gotN == b0, "R8 keep-alive no packet", doneN - d0 + gotN - b0, 0);

    // Transmitter owns the bus
    mark();
    txActive = 1'b1;
    startSeq();
    pushByte(8'h33, 8);
    endSeq();
    play(40);
    txActive = 1'b0;
    repeat (20) @(negedge clk);
    chk(gotN == b0 && doneN == d0 && markN == m0 && ovfN == o0, "R9 quiet while transmitting",
        gotN - b0 + doneN - d0 + markN - m0 + ovfN - o0, 0);
    mark();
    startSeq();
    pushByte(8'h81, 8);
    endSeq();
    play(40);
    chk(gotN - b0 == 1 && got[b0] == 8'h81, "R9 receive after transmit", int'(got[b0]), 129);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R1 act=%0d exp=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule